// File: doc/BRIEF.md
# Absolute Difference Carry-Save Accumulator

This block sums absolute pixel differences for block matching. It takes two streams of unsigned pixel samples. It never builds |x−y| as a binary number. A first adder stage forms x−y as x + ~y + 1 and keeps the carry-out. That carry-out is high when x ≥ y. The second stage is a carry-save accumulator. When the carry-out is high it adds the low bits of the difference. When the carry-out is low it adds their one's complement and injects the missing +1 through the free LSB position of the carry vector. Each accumulate step therefore costs one full-adder delay, with no carry propagation.

The same first stage also adds x+y for motion compensation. Its registered raw result and carry-out are exposed in both modes. Accumulation takes place only in difference mode. A start strobe, sent on the first sample of a block, throws away the previous total. A done strobe marks the cycle in which the carry and sum vectors hold the total for a full block. The sum of those two vectors, modulo 2^ACC_W, is the block's SAD. Converting them to one binary number is left to the consumer.

The input side is a valid/ready stream. `in_ready` is tied high, so the block never applies back-pressure. A sample transfers on every rising edge where `in_valid` is high. Nothing is held back for a later cycle.

Top module: `sad_csa_accum`

## Requirements
- R1: One cycle after a transfer, `res_out` shows the 9-bit adder result. In difference mode (`in_mode`=0) this is (x + ~y + 1) mod 512. In add mode (`in_mode`=1) it is x + y.
- R2: In difference mode, `ovr_out` (valid alongside `res_out`) is 1 when x ≥ y and 0 when x < y.
- R3: After the samples of a block are accepted in difference mode, `acc_carry + acc_sum` mod 2^16 equals the sum of |x−y| over those samples. This includes a block of equal pixels (total 0) and a block of 0/255 pairs (total 65280).
- R4: A transfer with `in_start`=1 in difference mode discards the previous total. The new total counts from that sample only.
- R5: `done` goes high for exactly one cycle, two cycles after the 256th difference-mode transfer since the last start. In that same cycle the vectors hold the full-block total. A partial block raises no `done`.
- R6: Add-mode transfers leave the carry and sum vectors unchanged and do not advance the block count.
- R7: Cycles with `in_valid`=0 change neither the vectors nor the block count, whatever the other inputs carry. A block with idle gaps gives the same total and one `done`.
- R8: After reset, both vectors, `res_out`, `ovr_out` and `done` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Always 1: no back-pressure |
| in_x | input | 8 | Current-block pixel |
| in_y | input | 8 | Reference-block pixel |
| in_mode | input | 1 | 0 = absolute difference accumulate, 1 = plain add |
| in_start | input | 1 | First sample of a block; only acts with in_valid |
| res_out | output | 9 | Registered adder result |
| ovr_out | output | 1 | Registered adder carry-out |
| acc_carry | output | 16 | Carry vector of the accumulator |
| acc_sum | output | 16 | Sum vector of the accumulator |
| done | output | 1 | One-cycle pulse: 256-sample total ready |

## Verification
The assertions assume that a block runs from a start no further than 256 difference-mode samples. This means that a single step never moves the vector total by more than one pixel's worth. The assertions also assume that `in_start` matters only together with `in_valid`. The stimulus opens every block with a start on its first valid sample. It sends exactly 256 difference-mode samples per full block. Partial blocks are always followed by a new start. During idle gaps the bench drives random values on x, y, mode and start, so that only `in_valid` keeps them out of the accumulator.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic {
    OP_ABSDIFF = 1'b0,
    OP_ADD     = 1'b1
  } op_e;
endpackage

// File: rtl/sad_diff_stage.sv
module sad_diff_stage
  import sad_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_x,
  input  logic [PIX_W-1:0] in_y,
  input  op_e              in_op,
  input  logic             in_start,
  output logic             out_valid,
  output logic [PIX_W:0]   out_res,
  output logic             out_ovr,
  output op_e              out_op,
  output logic             out_start
);
  logic [PIX_W-1:0] opnd_b;
  logic             cin;
  logic [PIX_W:0]   raw;

  // subtract as x + ~y + 1; add as x + y
  always_comb begin
    opnd_b = (in_op == OP_ADD) ? in_y : ~in_y;
    cin    = (in_op == OP_ABSDIFF);
    raw    = {1'b0, in_x} + {1'b0, opnd_b} + {{PIX_W{1'b0}}, cin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_ovr   <= 1'b0;
      out_op    <= OP_ABSDIFF;
      out_start <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res   <= raw;
        out_ovr   <= raw[PIX_W];
        out_op    <= in_op;
        out_start <= in_start;
      end
    end
  end

  // carry-out marks a non-negative difference
  assert_ovr_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_ABSDIFF) |=> (out_ovr == ($past(in_x) >= $past(in_y))));
endmodule

// File: rtl/sad_csa_acc.sv
module sad_csa_acc #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PIX_W-1:0] diff_lo,
  input  logic             ovr,
  output logic [ACC_W-1:0] acc_s,
  output logic [ACC_W-1:0] acc_c
);
  localparam int PAD = ACC_W - PIX_W;

  logic [ACC_W-1:0] opnd;
  logic             inj;
  logic [ACC_W-1:0] base_s, base_c;
  logic [ACC_W-1:0] fa_sum, fa_maj;

  always_comb begin
    opnd   = {{PAD{1'b0}}, (ovr ? diff_lo : ~diff_lo)};
    inj    = ~ovr;
    base_s = clr ? '0 : acc_s;
    base_c = clr ? '0 : acc_c;
  end

  for (genvar i = 0; i < ACC_W; i++) begin : g_fa
    assign fa_sum[i] = base_s[i] ^ base_c[i] ^ opnd[i];
    assign fa_maj[i] = (base_s[i] & base_c[i]) | (base_s[i] & opnd[i]) | (base_c[i] & opnd[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_s <= '0;
      acc_c <= '0;
    end else if (en) begin
      acc_s <= fa_sum;
      acc_c <= {fa_maj[ACC_W-2:0], inj};
    end
  end

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (ACC_W'(ACC_W'(acc_s + acc_c) - ACC_W'($past(acc_s) + $past(acc_c))) <= ACC_W'(2**PIX_W - 1)));
  assert_clear_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> (ACC_W'(acc_s + acc_c) <= ACC_W'(2**PIX_W - 1)));
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_s) && $stable(acc_c)));
endmodule

// File: rtl/sad_blk_count.sv
module sad_blk_count #(
  parameter int BLK = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic done
);
  localparam int CNT_W = $clog2(BLK) + 1;

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb cnt_nxt = clr ? CNT_W'(1) : cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= en && (cnt_nxt == CNT_W'(BLK));
      if (en) cnt <= cnt_nxt;
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(en));
endmodule

// File: rtl/sad_csa_accum.sv
module sad_csa_accum
  import sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = 16,
  parameter int BLK   = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_x,
  input  logic [PIX_W-1:0] in_y,
  input  logic             in_mode,
  input  logic             in_start,
  output logic [PIX_W:0]   res_out,
  output logic             ovr_out,
  output logic [ACC_W-1:0] acc_carry,
  output logic [ACC_W-1:0] acc_sum,
  output logic             done
);
  op_e  op_in, st_op;
  logic st_valid, st_start, acc_en;

  assign in_ready = 1'b1;
  assign op_in    = op_e'(in_mode);

  sad_diff_stage #(.PIX_W(PIX_W)) u_diff (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_op(op_in), .in_start(in_start),
    .out_valid(st_valid), .out_res(res_out), .out_ovr(ovr_out),
    .out_op(st_op), .out_start(st_start)
  );

  assign acc_en = st_valid && (st_op == OP_ABSDIFF);

  sad_csa_acc #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .clr(st_start),
    .diff_lo(res_out[PIX_W-1:0]), .ovr(ovr_out),
    .acc_s(acc_sum), .acc_c(acc_carry)
  );

  sad_blk_count #(.BLK(BLK)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .clr(st_start), .done(done)
  );

  assert_add_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode) |=> ##1 ($stable(acc_sum) && $stable(acc_carry)));
endmodule

// File: tb/tb_sad_csa_accum.sv
module tb_sad_csa_accum;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_mode = 0, in_start = 0;
  logic [7:0] in_x = 0, in_y = 0;
  logic in_ready, ovr_out, done;
  logic [8:0] res_out;
  logic [15:0] acc_carry, acc_sum;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, done_cnt = 0, done_cyc = -1, last_acc = 0;
  logic [15:0] done_tot = 0;
  bit [7:0] xs [256];
  bit [7:0] ys [256];

  always #2 clk = ~clk;

  sad_csa_accum dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) if (done) begin
    done_cnt++; done_cyc = cyc; done_tot = acc_carry + acc_sum;
  end

  function automatic logic [15:0] tot();
    return acc_carry + acc_sum;
  endfunction

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(bit [7:0] x, bit [7:0] y, bit m, bit st);
    @(negedge clk);
    in_valid = 1; in_x = x; in_y = y; in_mode = m; in_start = st;
    last_acc = cyc + 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_x = 8'($urandom); in_y = 8'($urandom);
      in_mode = 1'($urandom); in_start = 1'($urandom);
    end
  endtask

  // kind: 0 random, 1 all equal, 2 x=0/y=255, 3 x=255/y=0
  task automatic run_block(int kind, bit gaps, string req);
    int ref_sad = 0;
    int d0;
    for (int i = 0; i < 256; i++) begin
      case (kind)
        1: begin xs[i] = 8'($urandom); ys[i] = xs[i]; end
        2: begin xs[i] = 0; ys[i] = 255; end
        3: begin xs[i] = 255; ys[i] = 0; end
        default: begin xs[i] = 8'($urandom); ys[i] = 8'($urandom); end
      endcase
      ref_sad += absd(xs[i], ys[i]);
    end
    d0 = done_cnt;
    for (int i = 0; i < 256; i++) begin
      send(xs[i], ys[i], 1'b0, i == 0);
      if (gaps && ($urandom % 8 == 0)) idle(1 + $urandom % 3);
    end
    idle(4);
    chk({req, " done count"}, done_cnt - d0, 1);
    chk({req, " total"}, done_tot, ref_sad);
    chk("R5 done timing", done_cyc, last_acc + 1);
  endtask

  initial begin
    logic [15:0] t0;
    int d0, s;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 carry", acc_carry, 0);
    chk("R8 sum", acc_sum, 0);
    chk("R8 done", done, 0);
    chk("R8 res", res_out, 0);
    chk("R8 ready", in_ready, 1);
    rst_n = 1;

    // R1 / R2 raw results
    for (int k = 0; k < 12; k++) begin
      bit [7:0] x, y;
      bit m;
      x = (k == 0) ? 8'd5 : (k == 1) ? 8'd0 : 8'($urandom);
      y = (k == 0) ? 8'd5 : (k == 1) ? 8'd255 : 8'($urandom);
      m = (k >= 8);
      send(x, y, m, 1'b0);
      idle(1);
      if (!m) begin
        chk("R1 diff result", res_out, 9'({1'b0, x} + {1'b0, ~y} + 9'd1));
        chk("R2 ovr", ovr_out, (x >= y));
      end else
        chk("R1 add result", res_out, {1'b0, x} + {1'b0, y});
    end

    // R3 / R5 random and directed blocks
    run_block(0, 0, "R3 random");
    run_block(1, 0, "R3 equal");
    run_block(2, 0, "R3 neg max");
    run_block(3, 0, "R3 pos max");
    run_block(0, 0, "R3 random2");

    // R7 gaps and idle stability
    run_block(0, 1, "R7 gapped");
    t0 = tot();
    idle(5);
    chk("R7 idle hold", tot(), t0);

    // R6 add mode leaves vectors untouched
    send(8'd200, 8'd3, 1'b0, 1'b1);
    idle(2);
    t0 = tot();
    chk("R4 start clears", t0, 197);
    for (int i = 0; i < 5; i++) send(8'($urandom), 8'($urandom), 1'b1, 1'b0);
    idle(3);
    chk("R6 add hold", tot(), t0);

    // R4 partial block discarded, new block starts fresh; R5 no done on partial
    d0 = done_cnt;
    for (int i = 0; i < 40; i++) send(8'($urandom), 8'($urandom), 1'b0, i == 0);
    idle(3);
    chk("R5 partial no done", done_cnt - d0, 0);
    run_block(0, 0, "R4 restart");

    // R6 add samples interleaved do not advance count
    s = 0;
    d0 = done_cnt;
    for (int i = 0; i < 256; i++) begin
      xs[i] = 8'($urandom); ys[i] = 8'($urandom);
      s += absd(xs[i], ys[i]);
      send(xs[i], ys[i], 1'b0, i == 0);
      if (i % 32 == 5) send(8'($urandom), 8'($urandom), 1'b1, 1'b0);
    end
    idle(4);
    chk("R6 interleave done", done_cnt - d0, 1);
    chk("R6 interleave total", done_tot, s);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule